// File: doc/BRIEF.md
# Multi-Lane Word Gearbox Packer

This block gathers a set of narrow sample lanes that deliver in parallel, joins them into one input word per accepted cycle, and packs those words back to back into much wider output words for a memory write path. The output width need not be a whole multiple of the input width. Bits left over after an output word has been filled carry into the next output word, so the output is one continuous bit stream with no padding.

Each output word comes with a write address that steps by one per word and wraps around the address range. A count of the bits held back, waiting for the next output word, is reported on every cycle. An input word is taken only on a cycle where every lane is valid. The block has no backpressure: the downstream memory path must take every output word when it is offered.

The write address is not cleared by reset. When reset is first asserted, the address moves forward by two slots, so that words written after the reset do not land on the slot that may have been half written before it.

Top module: `gbx_packer`

## Requirements
- R1: Lane n occupies bits [LANE_W*n + LANE_W-1 : LANE_W*n] of the joined input word (lane 0 is least significant). A word is accepted only on a cycle where all bits of `in_valid` are 1 and `rst` is 0.
- R2: The accepted words form one little-endian bit stream, with earlier words in the lower bits. Output word k equals bits [OUT_W*(k+1)-1 : OUT_W*k] of that stream. An input word may be split across two output words.
- R3: `out_overflow` equals the total bits accepted minus the total bits emitted since reset, and it is always below OUT_W.
- R4: `out_valid` is high for exactly one cycle per completed output word, and only then. A word accepted at clock edge t that completes an output word makes `out_valid` high after edge t+1.
- R5: `out_addr` in successive output words increases by one and wraps from 2^ADDR_W-1 to 0.
- R6: While `rst` is high, `out_valid` is 0 and `out_overflow` is 0 one cycle later. Partial data and an input word in flight are discarded.
- R7: The address pointer starts at 0 at power-up and is not cleared by reset. Each edge at which `rst` is first seen high, after a cycle with `rst` low (or at power-up), advances the pointer by 2 modulo 2^ADDR_W. The first word after that reset uses the advanced pointer.
- R8: A cycle with any lane not valid changes nothing: two edges later `out_valid` is 0 and `out_overflow` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NUM_LANES | Per-lane valid flags |
| in_data | input | NUM_LANES*LANE_W | Lane samples, lane n at bits LANE_W*n upward |
| out_valid | output | 1 | A full output word is present |
| out_data | output | OUT_W | Packed output word |
| out_overflow | output | $clog2(OUT_W) | Bits held for the next output word |
| out_addr | output | ADDR_W | Write address of the current output word |

## Verification
A wrong bit count in the accumulator shows up on `out_overflow` two cycles after the word that caused it. It also moves the boundary between output words, so every later data word is misaligned and the valid pulses fall on the wrong cycles. A wrong shift or merge corrupts the very next emitted word. A wrong address pointer is visible on the next `out_valid`, and the error persists because the pointer never resynchronises. The bench therefore compares valid and overflow on every cycle, and data and address on every emitted word, against a bit-queue model.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

   // Width needed to hold a count from 0 up to and including max_val.
   function automatic int gbx_count_w(input int max_val);
      int w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

   // Advance a wrapping pointer by step, modulo 2**width.
   function automatic logic [31:0] gbx_wrap_add(input logic [31:0] base,
                                                input int          step,
                                                input int          width);
      logic [31:0] mask;
      mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
      return (base + 32'(step)) & mask;
   endfunction

endpackage

// File: rtl/gbx_lane_merge.sv
module gbx_lane_merge #(
   parameter int NUM_LANES = 12,
   parameter int LANE_W    = 14,
   localparam int IN_W     = NUM_LANES * LANE_W
) (
   input  logic [NUM_LANES-1:0] lane_valid,
   input  logic [IN_W-1:0]      lane_data,
   output logic                 word_ok,
   output logic [IN_W-1:0]      word
);

   // Each lane takes its own slice of the joined word, lane 0 lowest.
   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      assign word[g*LANE_W +: LANE_W] = lane_data[g*LANE_W +: LANE_W];
   end

   assign word_ok = &lane_valid;

endmodule

// File: rtl/gbx_capture.sv
module gbx_capture #(
   parameter int IN_W = 168
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            word_ok,
   input  logic [IN_W-1:0] word,
   output logic            cap_ok,
   output logic [IN_W-1:0] cap_word
);

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_ok   <= 1'b0;
         cap_word <= '0;
      end else begin
         cap_ok   <= word_ok;
         cap_word <= word;
      end
   end

endmodule

// File: rtl/gbx_accum.sv
module gbx_accum #(
   parameter int IN_W     = 168,
   parameter int OUT_W    = 576,
   parameter int CNT_W    = 10,
   localparam int ACC_W   = OUT_W + IN_W,
   localparam int SUM_W   = gbx_pkg::gbx_count_w(OUT_W + IN_W)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_ok,
   input  logic [IN_W-1:0]  cap_word,
   output logic             emit_next,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data,
   output logic [CNT_W-1:0] held_bits
);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] merged;
   logic [SUM_W-1:0] sum;

   // New word lands just above the bits already held.
   assign merged    = acc_q | (ACC_W'(cap_word) << held_bits);
   assign sum       = SUM_W'(held_bits) + SUM_W'(IN_W);
   assign emit_next = cap_ok && (sum >= SUM_W'(OUT_W));

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q     <= '0;
         held_bits <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= 1'b0;
         if (cap_ok) begin
            if (emit_next) begin
               out_valid <= 1'b1;
               out_data  <= merged[OUT_W-1:0];
               acc_q     <= merged >> OUT_W;
               held_bits <= CNT_W'(sum - SUM_W'(OUT_W));
            end else begin
               acc_q     <= merged;
               held_bits <= CNT_W'(sum);
            end
         end
      end
   end

endmodule

// File: rtl/gbx_addr_gen.sv
module gbx_addr_gen #(
   parameter int ADDR_W    = 12,
   parameter int RST_SKIP  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              emit_next,
   output logic [ADDR_W-1:0] out_addr
);

   logic [ADDR_W-1:0] ptr_q    = '0;
   logic [ADDR_W-1:0] addr_q   = '0;
   logic              rst_seen = 1'b0;

   always_ff @(posedge clk) begin
      rst_seen <= rst;
      if (rst) begin
         if (!rst_seen)
            ptr_q <= ADDR_W'(gbx_pkg::gbx_wrap_add(32'(ptr_q), RST_SKIP, ADDR_W));
      end else if (emit_next) begin
         addr_q <= ptr_q;
         ptr_q  <= ADDR_W'(gbx_pkg::gbx_wrap_add(32'(ptr_q), 1, ADDR_W));
      end
   end

   assign out_addr = addr_q;

endmodule

// File: rtl/gbx_packer.sv
module gbx_packer #(
   parameter int NUM_LANES = 12,
   parameter int LANE_W    = 14,
   parameter int OUT_W     = 576,
   parameter int ADDR_W    = 12,
   localparam int IN_W     = NUM_LANES * LANE_W,
   localparam int CNT_W    = $clog2(OUT_W)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_LANES-1:0] in_valid,
   input  logic [IN_W-1:0]      in_data,
   output logic                 out_valid,
   output logic [OUT_W-1:0]     out_data,
   output logic [CNT_W-1:0]     out_overflow,
   output logic [ADDR_W-1:0]    out_addr
);

   if (NUM_LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("gbx_packer: lane count and width must be positive");
   end
   if (IN_W > OUT_W) begin : g_bad_ratio
      $error("gbx_packer: joined input word wider than output word");
   end
   if (ADDR_W < 2 || ADDR_W > 31) begin : g_bad_addr
      $error("gbx_packer: address width out of range");
   end

   logic            word_ok;
   logic [IN_W-1:0] word;
   logic            cap_ok;
   logic [IN_W-1:0] cap_word;
   logic            emit_next;

   gbx_lane_merge #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) merge_i (
      .lane_valid(in_valid),
      .lane_data (in_data),
      .word_ok   (word_ok),
      .word      (word)
   );

   gbx_capture #(.IN_W(IN_W)) cap_i (
      .clk     (clk),
      .rst     (rst),
      .word_ok (word_ok),
      .word    (word),
      .cap_ok  (cap_ok),
      .cap_word(cap_word)
   );

   gbx_accum #(.IN_W(IN_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) acc_i (
      .clk      (clk),
      .rst      (rst),
      .cap_ok   (cap_ok),
      .cap_word (cap_word),
      .emit_next(emit_next),
      .out_valid(out_valid),
      .out_data (out_data),
      .held_bits(out_overflow)
   );

   gbx_addr_gen #(.ADDR_W(ADDR_W), .RST_SKIP(2)) addr_i (
      .clk      (clk),
      .rst      (rst),
      .emit_next(emit_next),
      .out_addr (out_addr)
   );

endmodule

// File: rtl/gbx_packer_chk.sv
module gbx_packer_chk #(
   parameter int NUM_LANES = 12,
   parameter int LANE_W    = 14,
   parameter int OUT_W     = 576,
   parameter int ADDR_W    = 12,
   localparam int IN_W     = NUM_LANES * LANE_W,
   localparam int CNT_W    = $clog2(OUT_W)
) (
   input logic                 clk,
   input logic                 rst,
   input logic [NUM_LANES-1:0] in_valid,
   input logic                 out_valid,
   input logic [CNT_W-1:0]     out_overflow,
   input logic [ADDR_W-1:0]    out_addr
);

   logic [ADDR_W-1:0] last_addr;
   logic              have_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         have_last <= 1'b0;
         last_addr <= '0;
      end else if (out_valid) begin
         have_last <= 1'b1;
         last_addr <= out_addr;
      end
   end

   // R3: held bit count stays below one output word
   p_ovf_bound_r3: assert property (@(posedge clk) disable iff (rst)
      int'(out_overflow) < OUT_W);

   // R3: emitting a word removes OUT_W bits and adds the new word's bits
   p_ovf_step_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (int'(out_overflow) + OUT_W == int'($past(out_overflow)) + IN_W));

   // R6: reset quiets the output and empties the held bits
   p_reset_quiet_r6: assert property (@(posedge clk)
      rst |=> (!out_valid && out_overflow == '0));

   // R5: consecutive words take consecutive addresses
   p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && have_last) |-> (out_addr == ADDR_W'(last_addr + 1'b1)));

   // R8: a cycle with a missing lane leaves the outputs alone
   p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(&in_valid, 2) && !$past(rst, 2) && !$past(rst, 1))
         |-> (!out_valid && $stable(out_overflow)));

endmodule

bind gbx_packer gbx_packer_chk #(
   .NUM_LANES(NUM_LANES), .LANE_W(LANE_W), .OUT_W(OUT_W), .ADDR_W(ADDR_W)
) chk_i (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .out_valid   (out_valid),
   .out_overflow(out_overflow),
   .out_addr    (out_addr)
);

// File: tb/gbx_packer_tb_top.sv
`timescale 1ns/1ps
module gbx_packer_tb_top;

   localparam int NUM_LANES = 12;
   localparam int LANE_W    = 14;
   localparam int OUT_W     = 576;
   localparam int ADDR_W    = 3;
   localparam int IN_W      = NUM_LANES * LANE_W;
   localparam int CNT_W     = $clog2(OUT_W);
   localparam int DEPTH     = 1 << ADDR_W;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic [NUM_LANES-1:0] in_valid = '0;
   logic [IN_W-1:0]      in_data  = '0;
   logic                 out_valid;
   logic [OUT_W-1:0]     out_data;
   logic [CNT_W-1:0]     out_overflow;
   logic [ADDR_W-1:0]    out_addr;

   always #2 clk = ~clk;

   gbx_packer #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W), .OUT_W(OUT_W), .ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data),
      .out_overflow(out_overflow), .out_addr(out_addr)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // ---------------- behavioural reference: a queue of bits ----------------
   bit               bitq[$];
   bit               m_s1_ok   = 1'b0;
   logic [IN_W-1:0]  m_s1      = '0;
   bit               m_prev_rst = 1'b0;
   int               m_ptr     = 0;
   bit               m_after_rst = 1'b0;
   bit               m_ignored = 1'b0;
   bit               m_in_rst  = 1'b0;
   bit               e_valid   = 1'b0;
   logic [OUT_W-1:0] e_data    = '0;
   int               e_ovf     = 0;
   int               e_addr    = 0;
   bit               e_first   = 1'b0;

   always @(posedge clk) begin
      if (rst) begin
         if (!m_prev_rst) m_ptr = (m_ptr + 2) % DEPTH;   // R7 skip
         bitq.delete();
         m_s1_ok     = 1'b0;
         e_valid     = 1'b0;
         e_ovf       = 0;
         m_after_rst = 1'b1;
         m_ignored   = 1'b0;
         m_in_rst    = 1'b1;
      end else begin
         m_in_rst  = 1'b0;
         e_valid   = 1'b0;
         m_ignored = !m_s1_ok;
         if (m_s1_ok) begin
            for (int i = 0; i < IN_W; i++) bitq.push_back(m_s1[i]);
            if (bitq.size() >= OUT_W) begin
               for (int i = 0; i < OUT_W; i++) e_data[i] = bitq.pop_front();
               e_valid     = 1'b1;
               e_addr      = m_ptr;
               e_first     = m_after_rst;
               m_after_rst = 1'b0;
               m_ptr       = (m_ptr + 1) % DEPTH;
            end
            e_ovf = bitq.size();
         end
         m_s1_ok = &in_valid;
         m_s1    = in_data;
      end
      m_prev_rst = rst;
   end

   task automatic chk_int(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   // Compare on every cycle, half a period after the edge.
   always @(negedge clk) begin
      if (!finished) begin
         chk_int(m_in_rst ? "R6 valid" : "R4 valid", int'(out_valid), int'(e_valid));
         chk_int(m_in_rst ? "R6 overflow" : (m_ignored ? "R8 overflow" : "R3 overflow"),
                 int'(out_overflow), e_ovf);
         if (e_valid && out_valid) begin
            n_cmp++;
            if (out_data !== e_data) begin
               n_bad++;
               $display("FAIL R2 data (lane order R1) at %0t: actual %h expected %h",
                        $time, out_data, e_data);
            end
            chk_int(e_first ? "R7 address" : "R5 address", int'(out_addr), e_addr);
         end
      end
   end

   // ---------------- stimulus ----------------
   int slot = 0;

   task automatic drive(input bit full, input int gap_lane);
      @(negedge clk);
      for (int l = 0; l < NUM_LANES; l++) begin
         in_data[l*LANE_W +: LANE_W] = LANE_W'(slot);
         slot++;
      end
      if (!full) begin
         in_valid = '0;
      end else if (gap_lane >= 0) begin
         in_valid = '1;
         in_valid[gap_lane] = 1'b0;          // R8: one lane missing
         in_data  = '1;
         slot     = slot - NUM_LANES;
      end else begin
         in_valid = '1;
      end
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      rst = 1'b1;
      repeat (5) drive(1'b1, -1);            // R6: inputs ignored in reset
      @(negedge clk); rst = 1'b0;
      slot = 0;
      // continuous stream, incrementing lane pattern (R1, R2, R4, R5 wrap)
      for (int k = 0; k < 60; k++) drive(1'b1, -1);
      // gaps with one missing lane (R8)
      for (int k = 0; k < 40; k++) drive(1'b1, (k % 3 == 2) ? (k % NUM_LANES) : -1);
      // idle cycles (R8)
      repeat (5) drive(1'b0, -1);
      for (int k = 0; k < 7; k++) drive(1'b1, -1);
      // reset in the middle of a stream (R6, R7)
      @(negedge clk); rst = 1'b1;
      repeat (2) drive(1'b1, -1);
      @(negedge clk); rst = 1'b0;
      for (int k = 0; k < 30; k++) drive(1'b1, -1);
      repeat (4) drive(1'b0, -1);
      @(negedge clk);
      finish_run();
   end

   initial begin
      #(4 * 20000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule